// File: doc/BRIEF.md
# Block-Transfer DMA Request Channel

This block is one request channel of a crypto peripheral's DMA support. A peripheral normally carries two instances of it. The channel watches a small set of engine events and raises a burst request to an external DMA controller when the event picked by its trigger-select field occurs. Software can also raise the request by writing this channel's bit in a shared manual-trigger word.

Once the channel is armed, the DMA moves data through one window location. The channel turns each access into a byte address inside a 16-byte target, beginning at the word chosen by a start field. It advances that address by the width of each access and wraps it within the target. The channel counts bytes until the block is full. It then gives a one-cycle done pulse, which also sets the channel's done interrupt, together with the configured done actions that can gate or start the next encryption.

Top module: `crypto_dma_channel`

## Requirements
- R1: After reset, `dma_req`, `done_o` and `done_act_o` are all zero.
- R2: While idle, a one-cycle pulse on `evt_i[k-1]` with `cfg_trig_sel` equal to k (k = 1..NUM_EVT) sets `dma_req` from the next clock edge. Select value 0 and values above NUM_EVT never raise a request.
- R3: While idle, a cycle with `trig_wr` high and the channel's bit of `trig_wdata` set raises `dma_req` from the next edge. Channel A uses bit 3 and channel B uses bit 2, chosen by parameter `IS_CH_A`.
- R4: `dma_req` falls at the edge that accepts the first access. Trigger events that arrive while a transfer is in flight are ignored, so no request follows the done pulse.
- R5: The first access of a transfer is at byte address 4 * `cfg_start_word`, latched when the channel arms. Each accepted access advances `win_addr` by its size in bytes, modulo 16.
- R6: An access with `acc_size` = 3 is ignored. It does not advance the address, does not drop the request and does not count toward completion. Sizes 0, 1 and 2 mean 1, 2 and 4 bytes.
- R7: `done_o` is high for exactly one cycle: the cycle after the accepted access that brings the byte count to 16 or more. The channel is then idle.
- R8: `done_act_o` equals `cfg_done_act` during the done pulse and is zero at all other times. If bit 1 (gate on channel A) and bit 2 (delayed gate on channel A) are both set, bit 2 is cleared. Bit 0 starts an encryption and bit 3 gates on channel B.
- R9: Accesses made while the channel is idle have no effect. No done pulse follows, and `win_addr` stays at the start byte of the last transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_trig_sel | input | SEL_W | Trigger condition select |
| cfg_start_word | input | START_W | Start word within the target |
| cfg_done_act | input | ACT_W | Actions to take at completion |
| evt_i | input | NUM_EVT | Engine event pulses |
| trig_wr | input | 1 | Manual-trigger word write strobe |
| trig_wdata | input | TRIG_W | Manual-trigger word data |
| dma_req | output | 1 | Burst request to the DMA controller |
| acc_vld | input | 1 | DMA access to the window |
| acc_size | input | 2 | Access width code |
| win_addr | output | ADDR_W | Byte address of the current access |
| win_en | output | 1 | Access accepted this cycle |
| done_o | output | 1 | Block complete pulse (done interrupt set) |
| done_act_o | output | ACT_W | Done actions, valid with done_o |

## Verification
The bench builds the channel with a 16-byte block, three events and a 3-bit select, in two instances: one as channel A and one as channel B. With this small configuration, every start word can be combined with every access width and all sixteen done-action codes. That includes the overshooting mixed-width pattern and the conflicting gate pair. Every select value can also be tried against every event line.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  localparam int ACT_GATE_A     = 1;
  localparam int ACT_GATE_A_DLY = 2;

  // bytes moved by one access; zero for the unsupported code
  function automatic logic [2:0] size_to_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_to_bytes = 3'd1;
      SZ_HALF: size_to_bytes = 3'd2;
      SZ_WORD: size_to_bytes = 3'd4;
      default: size_to_bytes = 3'd0;
    endcase
  endfunction

  // gate-on-A wins over its delayed variant
  function automatic logic [3:0] fix_done_act(input logic [3:0] a);
    logic [3:0] r;
    r = a;
    if (a[ACT_GATE_A] && a[ACT_GATE_A_DLY]) r[ACT_GATE_A_DLY] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/dmach_trig_sel.sv
module dmach_trig_sel #(
  parameter int SEL_W   = 3,
  parameter int NUM_EVT = 3,
  parameter int TRIG_W  = 4,
  parameter int MAN_BIT = 3
) (
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_EVT-1:0] evt,
  input  logic               man_wr,
  input  logic [TRIG_W-1:0]  man_data,
  output logic               fire
);
  logic [NUM_EVT-1:0] evt_hit;
  logic [TRIG_W-1:0]  man_hit;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    assign evt_hit[g] = evt[g] && (sel == SEL_W'(g + 1));
  end

  for (genvar b = 0; b < TRIG_W; b++) begin : g_man
    assign man_hit[b] = man_wr && man_data[b] && (b == MAN_BIT);
  end

  assign fire = (|evt_hit) || (|man_hit);
endmodule

// File: rtl/dmach_addr_ctr.sv
module dmach_addr_ctr #(
  parameter int BLOCK_BYTES = 16,
  parameter int START_W     = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           load,
  input  logic [START_W-1:0]             start_word,
  input  logic                           step,
  input  logic [2:0]                     step_bytes,
  output logic [$clog2(BLOCK_BYTES)-1:0] addr,
  output logic                           last
);
  localparam int ADDR_W = $clog2(BLOCK_BYTES);
  localparam int CNT_W  = ADDR_W + 1;

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W:0]    cnt_nxt;

  assign cnt_nxt = (CNT_W + 1)'(cnt_q) + (CNT_W + 1)'(step_bytes);
  assign last    = cnt_nxt >= (CNT_W + 1)'(BLOCK_BYTES);
  assign addr    = base_q + cnt_q[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= ADDR_W'(start_word) << 2;
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q <= last ? '0 : CNT_W'(cnt_nxt);
    end
  end

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(BLOCK_BYTES))
    else $error("byte count left the block");

  p_idle_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(addr))
    else $error("address moved without an accepted access");
endmodule

// File: rtl/dmach_done_act.sv
module dmach_done_act #(
  parameter int ACT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             finish,
  input  logic [ACT_W-1:0] cfg_act,
  output logic             done,
  output logic [ACT_W-1:0] act
);
  import dmach_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      act  <= '0;
    end else begin
      done <= finish;
      act  <= finish ? ACT_W'(fix_done_act(4'(cfg_act))) : '0;
    end
  end

  p_act_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(act[ACT_GATE_A] && act[ACT_GATE_A_DLY]))
    else $error("conflicting gate actions");

  p_act_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act != '0) |-> done)
    else $error("action outside done pulse");
endmodule

// File: rtl/crypto_dma_channel.sv
module crypto_dma_channel #(
  parameter int BLOCK_BYTES = 16,
  parameter int SEL_W       = 3,
  parameter int NUM_EVT     = 3,
  parameter int START_W     = 2,
  parameter int ACT_W       = 4,
  parameter int TRIG_W      = 4,
  parameter bit IS_CH_A     = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [SEL_W-1:0]               cfg_trig_sel,
  input  logic [START_W-1:0]             cfg_start_word,
  input  logic [ACT_W-1:0]               cfg_done_act,
  input  logic [NUM_EVT-1:0]             evt_i,
  input  logic                           trig_wr,
  input  logic [TRIG_W-1:0]              trig_wdata,
  output logic                           dma_req,
  input  logic                           acc_vld,
  input  logic [1:0]                     acc_size,
  output logic [$clog2(BLOCK_BYTES)-1:0] win_addr,
  output logic                           win_en,
  output logic                           done_o,
  output logic [ACT_W-1:0]               done_act_o
);
  import dmach_pkg::*;

  localparam int MAN_BIT = IS_CH_A ? 3 : 2;

  logic       fire, arm, acc_ok, last, finish;
  logic       active_q, req_q;
  logic [2:0] step_bytes;

  dmach_trig_sel #(
    .SEL_W(SEL_W), .NUM_EVT(NUM_EVT), .TRIG_W(TRIG_W), .MAN_BIT(MAN_BIT)
  ) u_trig (
    .sel(cfg_trig_sel), .evt(evt_i), .man_wr(trig_wr),
    .man_data(trig_wdata), .fire(fire)
  );

  assign step_bytes = size_to_bytes(acc_size);
  assign arm        = fire && !active_q;
  assign acc_ok     = acc_vld && active_q && (step_bytes != 3'd0);
  assign finish     = acc_ok && last;

  dmach_addr_ctr #(.BLOCK_BYTES(BLOCK_BYTES), .START_W(START_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(arm), .start_word(cfg_start_word),
    .step(acc_ok), .step_bytes(step_bytes), .addr(win_addr), .last(last)
  );

  dmach_done_act #(.ACT_W(ACT_W)) u_done (
    .clk(clk), .rst_n(rst_n), .finish(finish), .cfg_act(cfg_done_act),
    .done(done_o), .act(done_act_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      if (arm)         active_q <= 1'b1;
      else if (finish) active_q <= 1'b0;
      if (arm)         req_q <= 1'b1;
      else if (acc_ok) req_q <= 1'b0;
    end
  end

  assign dma_req = req_q;
  assign win_en  = acc_ok;

  p_req_in_flight_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> active_q)
    else $error("request while idle");

  p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_en |=> !dma_req)
    else $error("request kept after access");

  p_done_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $fell(active_q))
    else $error("done without end of transfer");

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o)
    else $error("done wider than one cycle");
endmodule

// File: tb/tb_crypto_dma_channel.sv
module tb_crypto_dma_channel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_trig_sel = '0;
  logic [1:0] cfg_start_word = '0;
  logic [3:0] cfg_done_act = '0;
  logic [2:0] evt_i = '0;
  logic       trig_wr = 1'b0;
  logic [3:0] trig_wdata = '0;
  logic       acc_vld = 1'b0;
  logic [1:0] acc_size = '0;
  logic       dma_req, win_en, done_o, req_b, en_b, done_b;
  logic [3:0] win_addr, done_act_o, addr_b, act_b;
  int nchk = 0, nerr = 0;

  always #10 clk = ~clk;

  crypto_dma_channel dut (
    .clk(clk), .rst_n(rst_n), .cfg_trig_sel(cfg_trig_sel),
    .cfg_start_word(cfg_start_word), .cfg_done_act(cfg_done_act),
    .evt_i(evt_i), .trig_wr(trig_wr), .trig_wdata(trig_wdata),
    .dma_req(dma_req), .acc_vld(acc_vld), .acc_size(acc_size),
    .win_addr(win_addr), .win_en(win_en), .done_o(done_o),
    .done_act_o(done_act_o)
  );

  crypto_dma_channel #(.IS_CH_A(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .cfg_trig_sel(cfg_trig_sel),
    .cfg_start_word(cfg_start_word), .cfg_done_act(cfg_done_act),
    .evt_i(evt_i), .trig_wr(trig_wr), .trig_wdata(trig_wdata),
    .dma_req(req_b), .acc_vld(acc_vld), .acc_size(acc_size),
    .win_addr(addr_b), .win_en(en_b), .done_o(done_b),
    .done_act_o(act_b)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int width_of(input int code);
    return 1 << code;
  endfunction

  function automatic int pick_size(input int mode, input int k);
    if (mode < 3) return mode;
    return 2 - (k % 3);
  endfunction

  // runs the accesses of an armed transfer and checks its completion
  task automatic run_xfer(input int start, input int mode, input logic [3:0] act);
    int sent = 0;
    int k = 0;
    logic [3:0] exp_act;
    exp_act = act & ~({act[1], 2'b00});
    while (sent < 16) begin
      if (mode == 3 && k == 1) begin
        acc_vld = 1'b1; acc_size = 2'd3;
        tick();
        acc_vld = 1'b0;
        chk("R6 bad size keeps address", 32'(win_addr), 32'((start * 4 + sent) % 16));
        chk("R6 bad size no done", 32'(done_o), 0);
        cfg_trig_sel = 3'd1; evt_i = 3'b001;
        tick();
        evt_i = 3'b000; cfg_trig_sel = 3'd0;
      end
      chk("R5 access address", 32'(win_addr), 32'((start * 4 + sent) % 16));
      acc_vld = 1'b1; acc_size = 2'(pick_size(mode, k));
      tick();
      acc_vld = 1'b0;
      if (k == 0) chk("R4 request drops on first access", 32'(dma_req), 0);
      sent += width_of(pick_size(mode, k));
      k++;
      if (sent < 16) chk("R7 no early done", 32'(done_o), 0);
    end
    chk("R7 done pulse", 32'(done_o), 1);
    chk("R8 done action", 32'(done_act_o), 32'(exp_act));
    tick();
    chk("R7 done one cycle", 32'(done_o), 0);
    chk("R8 action cleared", 32'(done_act_o), 0);
    chk("R4 no request after done", 32'(dma_req), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R1 reset req", 32'(dma_req), 0);
    chk("R1 reset done", 32'(done_o), 0);
    chk("R1 reset action", 32'(done_act_o), 0);
    rst_n = 1'b1;
    tick();
    chk("R1 req after reset", 32'({dma_req, req_b}), 0);

    // R2: every select value against every event line
    for (int s = 0; s < 8; s++) begin
      for (int e = 0; e < 3; e++) begin
        cfg_trig_sel = 3'(s); cfg_start_word = 2'(e);
        evt_i = 3'(1 << e);
        tick();
        evt_i = '0; cfg_trig_sel = '0;
        chk("R2 event select", 32'(dma_req), 32'(s == e + 1));
        if (s == e + 1) run_xfer(e, 2, 4'h0);
      end
    end

    // R3: manual trigger bits per channel
    trig_wr = 1'b1; trig_wdata = 4'b0100;
    tick();
    trig_wr = 1'b0;
    chk("R3 channel A ignores bit 2", 32'(dma_req), 0);
    chk("R3 channel B takes bit 2", 32'(req_b), 1);

    // finish channel B alone (A is idle, accesses ignored there: R9)
    cfg_start_word = 2'd0;
    for (int i = 0; i < 4; i++) begin
      acc_vld = 1'b1; acc_size = 2'd2;
      tick();
      acc_vld = 1'b0;
    end
    chk("R7 channel B done", 32'(done_b), 1);
    chk("R9 idle channel A no done", 32'(done_o), 0);
    tick();

    // sweep start words, access patterns and done actions
    for (int st = 0; st < 4; st++) begin
      for (int m = 0; m < 4; m++) begin
        for (int a = 0; a < 16; a++) begin
          cfg_start_word = 2'(st); cfg_done_act = 4'(a);
          trig_wr = 1'b1; trig_wdata = 4'b1000;
          tick();
          trig_wr = 1'b0;
          chk("R3 manual request channel A", 32'(dma_req), 1);
          chk("R3 channel B ignores bit 3", 32'(req_b), 0);
          run_xfer(st, m, 4'(a));
        end
        // R9: idle accesses change nothing
        for (int i = 0; i < 5; i++) begin
          acc_vld = 1'b1; acc_size = 2'd2;
          tick();
          acc_vld = 1'b0;
          chk("R9 idle no done", 32'(done_o), 0);
          chk("R9 idle address held", 32'(win_addr), 32'(st * 4));
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule